// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM with 1,024 rows and keeps every row refreshed. A free-running interval timer raises one refresh request every `REFRESH_CLKS` clocks. With the default of 31,250 clocks at 250 MHz, that is one request every 125 µs, which covers the whole array in 128 ms. Each request becomes one refresh cycle.

The refresh style is chosen by `mode_ras_only`:

- **CAS-before-RAS:** the device's own row counter picks the row.
- **RAS-only:** the block drives `row_addr` from its own 10-bit counter.

A single access requester competes with refresh through a level handshake: `acc_req` is answered by `acc_gnt`. During the grant the block holds RAS# low and leaves the column strobes to the access path. On `sleep_req` the block places the device in self refresh. When `sleep_req` is released it leaves self refresh with a long precharge. In RAS-only mode it then runs a back-to-back refresh of all rows before it grants any access.

The sequencer has these states:

| State | Strobes | Leaves when |
|---|---|---|
| IDLE | all high | A choice is made in this order: catch-up, then pending refresh, then sleep, then access. It goes to ROR_STROBE, CBR_SETUP, SR_SETUP or ACCESS. |
| CBR_SETUP | both CAS lanes low, WE# high | After `T_CSR` clocks, to CBR_STROBE |
| CBR_STROBE | RAS# also low | After `T_RAS` clocks, to PRECHARGE |
| ROR_STROBE | RAS# low, CAS high | After `T_RAS` clocks, to PRECHARGE; the row counter steps |
| PRECHARGE | all high | After `T_RP` clocks, to IDLE |
| ACCESS | RAS# low, grant high | When `acc_req` drops, to PRECHARGE |
| SR_SETUP | CAS low | After `T_CSR` clocks, to SR_HOLD |
| SR_HOLD | RAS# and CAS low | After `T_RASS` clocks and with `sleep_req` low, to SR_EXIT |
| SR_EXIT | all high | After `T_RPS` clocks, to IDLE |

Every timed state lasts exactly its count of clocks. All counts must be at least 1, and `T_RASS` must be at least 2. `mode_ras_only` should change only while no refresh is under way.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, RAS#, both CAS# lanes and WE# are high. In addition, `row_addr` is 0, `acc_gnt` and `sleep_ack` are low, and `ovf_err` is clear.
- R2: With no other activity in CAS-before-RAS mode (`mode_ras_only`=0), exactly one refresh cycle runs per `REFRESH_CLKS` clocks. The first one is requested `REFRESH_CLKS` clocks after reset.
- R3: A CAS-before-RAS cycle has four parts. First, both CAS# lanes are low together with WE# high for exactly `T_CSR` clocks before RAS# falls. Next, RAS# stays low for exactly `T_RAS` clocks. Then CAS# and RAS# rise together. Finally, RAS# stays high for at least `T_RP` clocks before it falls again.
- R4: In RAS-only mode (`mode_ras_only`=1), CAS# stays high during refresh and RAS# stays low for `T_RAS` clocks. `row_addr` carries the row while RAS# is low. After each such cycle the row counter steps by one, wrapping from 1023 to 0.
- R5: When idle, `acc_req`=1 gets `acc_gnt`=1 with RAS# low and CAS# high. The grant lasts while `acc_req` stays high. One clock after `acc_req` drops, the grant and RAS# are released.
- R6: Refresh requests that arrive during an access are counted, up to `PEND_MAX` (8). All counted refreshes run before the next grant.
- R7: A refresh request that arrives while `PEND_MAX` are already pending sets `ovf_err`, which stays set until reset.
- R8: Sleep entry starts like a CAS-before-RAS cycle and then holds RAS# and CAS# low. `sleep_ack` rises once RAS# has been low for `T_RASS`-1 clocks. RAS# then stays low for at least `T_RASS` clocks, and for as long as `sleep_req` stays high.
- R9: On exit, `sleep_ack` drops and RAS# rises at once. RAS# then stays high for at least `T_RPS` clocks before any new cycle.
- R10: In CAS-before-RAS mode, no burst follows the exit. An access requested at wake is granted within `T_RPS`+`T_CSR`+`T_RAS`+`T_RP`+4 clocks, with at most one refresh cycle before it.
- R11: In RAS-only mode, at least 1,024 RAS-only refresh cycles run after the exit before any access is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects RAS-only refresh; 0 selects CAS-before-RAS refresh |
| acc_req | input | 1 | Access request, a level held for the whole access |
| sleep_req | input | 1 | High requests self refresh; low requests wake |
| acc_gnt | output | 1 | Access granted; RAS# is held low |
| sleep_ack | output | 1 | The device has been held in self refresh long enough; exit may begin |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low; high in every refresh cycle |
| row_addr | output | 10 | Row for RAS-only refresh |
| ovf_err | output | 1 | Sticky pending-refresh overflow flag |

## Verification
The strobes are decoded from the registered state, so a change decided at one clock edge shows up at the ports right after that edge. The bench therefore samples on the falling edge.

A monitor counts the falling edges of each strobe's low and high runs. Each run length is checked when the run ends:

- CAS low for `T_CSR` clocks before RAS# falls.
- RAS# low for `T_RAS` clocks.
- RAS# high for at least `T_RP`, or at least `T_RPS` after a wake.
- `sleep_ack` rising after `T_RASS`-1 clocks of RAS# low.

The grant is due two clocks after a request in IDLE and is released one clock after the request drops. Counted refreshes are tied to the phase of the timer by aligning each test to an observed refresh. The hold windows are then chosen with about 100 clocks of margin on either side of each expected request.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CBR_SETUP,
        ST_CBR_STROBE,
        ST_ROR_STROBE,
        ST_PRECHARGE,
        ST_ACCESS,
        ST_SR_SETUP,
        ST_SR_HOLD,
        ST_SR_EXIT
    } seq_state_e;

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
    parameter int unsigned PERIOD = 31250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == W'(PERIOD - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == W'(PERIOD - 1));

    generate
        if (PERIOD > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr #(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic pending,
    output logic ovf_err
);
    localparam int unsigned W = $clog2(DEPTH + 1);

    logic [W-1:0] cnt_q;
    logic         err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: begin
                    if (cnt_q == W'(DEPTH)) err_q <= 1'b1;
                    else                    cnt_q <= cnt_q + 1'b1;
                end
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign pending = (cnt_q != '0);
    assign ovf_err = err_q;

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(DEPTH)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R7

endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
    parameter int unsigned ROWS = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    output logic [$clog2(ROWS)-1:0]  row
);
    localparam int unsigned W = $clog2(ROWS);

    logic [W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= (row_q == W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end
    end

    assign row = row_q;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q != $past(row_q)) |-> ((row_q == $past(row_q) + 1'b1) || (row_q == '0))); // R4

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter int unsigned REFRESH_CLKS = 31250,
    parameter int unsigned ROW_COUNT    = 1024,
    parameter int unsigned PEND_MAX     = 8,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned T_RAS        = 12,
    parameter int unsigned T_RP         = 8,
    parameter int unsigned T_RASS       = 25000,
    parameter int unsigned T_RPS        = 28
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_ras_only,
    input  logic                          acc_req,
    input  logic                          sleep_req,
    output logic                          acc_gnt,
    output logic                          sleep_ack,
    output logic                          ras_n,
    output logic                          casl_n,
    output logic                          cash_n,
    output logic                          we_n,
    output logic [$clog2(ROW_COUNT)-1:0]  row_addr,
    output logic                          ovf_err
);
    localparam int unsigned M1      = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int unsigned M2      = (T_RP > T_RPS) ? T_RP : T_RPS;
    localparam int unsigned M3      = (M1 > M2) ? M1 : M2;
    localparam int unsigned T_MAX   = (M3 > T_RASS) ? M3 : T_RASS;
    localparam int unsigned CNT_W   = $clog2(T_MAX + 1);
    localparam int unsigned CATCH_W = $clog2(ROW_COUNT + 1);

    seq_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CATCH_W-1:0] catch_q;
    logic               tick, pending, in_sr;
    logic               pend_take, pend_clr, catch_take, catch_load, row_step;

    drs_interval_timer #(.PERIOD(REFRESH_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign in_sr = (state_q == ST_SR_SETUP) || (state_q == ST_SR_HOLD) || (state_q == ST_SR_EXIT);

    drs_pend_ctr #(.DEPTH(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .inc(tick && !in_sr && !pend_clr), .dec(pend_take),
        .clr(pend_clr), .pending(pending), .ovf_err(ovf_err)
    );

    drs_row_ctr #(.ROWS(ROW_COUNT)) u_row (
        .clk(clk), .rst_n(rst_n), .step(row_step), .row(row_addr)
    );

    // Next-state and counter reload
    always_comb begin
        state_d    = state_q;
        cnt_d      = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        pend_take  = 1'b0;
        pend_clr   = 1'b0;
        catch_take = 1'b0;
        catch_load = 1'b0;
        row_step   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (catch_q != '0) begin
                    catch_take = 1'b1;
                    state_d    = ST_ROR_STROBE;
                    cnt_d      = CNT_W'(T_RAS - 1);
                end else if (pending) begin
                    pend_take = 1'b1;
                    if (mode_ras_only) begin
                        state_d = ST_ROR_STROBE;
                        cnt_d   = CNT_W'(T_RAS - 1);
                    end else begin
                        state_d = ST_CBR_SETUP;
                        cnt_d   = CNT_W'(T_CSR - 1);
                    end
                end else if (sleep_req) begin
                    pend_clr = 1'b1;
                    state_d  = ST_SR_SETUP;
                    cnt_d    = CNT_W'(T_CSR - 1);
                end else if (acc_req) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_CBR_SETUP: if (cnt_q == '0) begin
                state_d = ST_CBR_STROBE;
                cnt_d   = CNT_W'(T_RAS - 1);
            end
            ST_CBR_STROBE: if (cnt_q == '0) begin
                state_d = ST_PRECHARGE;
                cnt_d   = CNT_W'(T_RP - 1);
            end
            ST_ROR_STROBE: if (cnt_q == '0) begin
                row_step = 1'b1;
                state_d  = ST_PRECHARGE;
                cnt_d    = CNT_W'(T_RP - 1);
            end
            ST_PRECHARGE: if (cnt_q == '0) state_d = ST_IDLE;
            ST_ACCESS: if (!acc_req) begin
                state_d = ST_PRECHARGE;
                cnt_d   = CNT_W'(T_RP - 1);
            end
            ST_SR_SETUP: if (cnt_q == '0) begin
                state_d = ST_SR_HOLD;
                cnt_d   = CNT_W'(T_RASS - 1);
            end
            ST_SR_HOLD: if ((cnt_q == '0) && !sleep_req) begin
                state_d = ST_SR_EXIT;
                cnt_d   = CNT_W'(T_RPS - 1);
            end
            ST_SR_EXIT: if (cnt_q == '0) begin
                catch_load = mode_ras_only;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            catch_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (catch_load)      catch_q <= CATCH_W'(ROW_COUNT);
            else if (catch_take) catch_q <= catch_q - 1'b1;
        end
    end

    // Strobe decode
    always_comb begin
        ras_n     = 1'b1;
        casl_n    = 1'b1;
        we_n      = 1'b1;
        acc_gnt   = 1'b0;
        sleep_ack = 1'b0;
        unique case (state_q)
            ST_CBR_SETUP, ST_SR_SETUP: casl_n = 1'b0;
            ST_CBR_STROBE: begin
                casl_n = 1'b0;
                ras_n  = 1'b0;
            end
            ST_SR_HOLD: begin
                casl_n    = 1'b0;
                ras_n     = 1'b0;
                sleep_ack = (cnt_q == '0);
            end
            ST_ROR_STROBE: ras_n = 1'b0;
            ST_ACCESS: begin
                ras_n   = 1'b0;
                acc_gnt = 1'b1;
            end
            default: ras_n = 1'b1;
        endcase
        cash_n = casl_n;
    end

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !casl_n) |-> !$past(casl_n)); // R3
    AST_ACK_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> (!ras_n && !casl_n && !cash_n)); // R8
    AST_EXIT_RAISES_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_ack) |-> ras_n); // R9
    AST_CATCHUP_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (catch_q != '0) |-> !acc_gnt); // R11

endmodule

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
    localparam int PER   = 200;
    localparam int TCSR  = 2;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int TRASS = 10;
    localparam int TRPS  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ras_only = 1'b0, acc_req = 1'b0, sleep_req = 1'b0;
    logic acc_gnt, sleep_ack, ras_n, casl_n, cash_n, we_n, ovf_err;
    logic [9:0] row_addr;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int cbr_cnt = 0, ror_cnt = 0, exp_row = 0;
    int ras_low_cnt = 0, ras_high_cnt = 1000, cas_low_cnt = 0;
    int kind = 0;
    bit prev_ras = 1'b1, prev_ack = 1'b0, saw_ack = 1'b0, after_sr = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .REFRESH_CLKS(PER), .ROW_COUNT(1024), .PEND_MAX(8), .T_CSR(TCSR),
        .T_RAS(TRAS), .T_RP(TRP), .T_RASS(TRASS), .T_RPS(TRPS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only), .acc_req(acc_req),
        .sleep_req(sleep_req), .acc_gnt(acc_gnt), .sleep_ack(sleep_ack), .ras_n(ras_n),
        .casl_n(casl_n), .cash_n(cash_n), .we_n(we_n), .row_addr(row_addr), .ovf_err(ovf_err)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_refresh(input int cycles);
        return cycles / PER;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Strobe monitor: run lengths checked when each run ends
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1'b1; prev_ack = 1'b0; saw_ack = 1'b0; after_sr = 1'b0;
            ras_low_cnt = 0; ras_high_cnt = 1000; cas_low_cnt = 0;
            cbr_cnt = 0; ror_cnt = 0; exp_row = 0; kind = 0;
        end else begin
            if (prev_ras && !ras_n) begin
                check(ras_high_cnt >= (after_sr ? TRPS : TRP), after_sr ? "R9" : "R3",
                      "RAS high before fall", ras_high_cnt, after_sr ? TRPS : TRP);
                after_sr = 1'b0;
                saw_ack = 1'b0;
                if (acc_gnt) begin
                    kind = 0;
                    check(casl_n && cash_n, "R5", "CAS high in access", casl_n, 1);
                end else if (!casl_n) begin
                    kind = 1;
                    check(cas_low_cnt == TCSR, "R3", "CAS setup clocks", cas_low_cnt, TCSR);
                    check(we_n && !cash_n, "R3", "WE high, both lanes low", {we_n, cash_n}, 2);
                end else begin
                    kind = 2;
                    check(row_addr == 10'(exp_row), "R4", "row address", row_addr, exp_row);
                end
            end
            if (!prev_ras && ras_n) begin
                if (saw_ack) begin
                    check(ras_low_cnt >= TRASS, "R8", "self refresh RAS low", ras_low_cnt, TRASS);
                    after_sr = 1'b1;
                end else if (kind == 1) begin
                    check(ras_low_cnt == TRAS, "R3", "CBR RAS low", ras_low_cnt, TRAS);
                    check(casl_n && cash_n, "R3", "CAS rises with RAS", casl_n, 1);
                    cbr_cnt++;
                end else if (kind == 2) begin
                    check(ras_low_cnt == TRAS, "R4", "RAS-only RAS low", ras_low_cnt, TRAS);
                    ror_cnt++;
                    exp_row = (exp_row + 1) % 1024;
                end
            end
            if (!prev_ack && sleep_ack)
                check(ras_low_cnt == TRASS - 1, "R8", "ack after RAS low", ras_low_cnt, TRASS - 1);
            if (sleep_ack) saw_ack = 1'b1;
            if (ras_n) begin ras_high_cnt++; ras_low_cnt = 0; end
            else       begin ras_low_cnt++;  ras_high_cnt = 0; end
            cas_low_cnt = casl_n ? 0 : cas_low_cnt + 1;
            prev_ras = ras_n;
            prev_ack = sleep_ack;
        end
    end

    task automatic do_reset(input logic mode);
        acc_req = 1'b0; sleep_req = 1'b0; mode_ras_only = mode;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_gnt(input int limit, output int waited);
        waited = 0;
        while (!acc_gnt && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic align_to_refresh();
        int c = cbr_cnt;
        int n = 0;
        while (cbr_cnt == c && n < 2 * PER) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int w, c0, hold, idle;
        void'($urandom(32'h00C0FFEE));

        // Reset state
        do_reset(1'b0);
        @(negedge clk);
        check(ras_n && casl_n && cash_n && we_n, "R1", "strobes in standby",
              {ras_n, casl_n, cash_n, we_n}, 15);
        check(row_addr == 0 && !acc_gnt && !sleep_ack && !ovf_err, "R1", "row/grant/ack/err",
              {row_addr, acc_gnt, sleep_ack, ovf_err}, 0);

        // Distributed CBR refresh
        repeat (3 * PER + 20) @(negedge clk);
        check(cbr_cnt == 3, "R2", "refreshes in 3 periods", cbr_cnt, 3);
        check(ror_cnt == 0, "R2", "no RAS-only in CBR mode", ror_cnt, 0);

        // Access handshake
        acc_req = 1'b1;
        wait_gnt(40, w);
        check(acc_gnt, "R5", "grant seen", acc_gnt, 1);
        repeat (10) @(negedge clk);
        check(acc_gnt && !ras_n && casl_n, "R5", "grant held, RAS low", {acc_gnt, ras_n, casl_n}, 5);
        acc_req = 1'b0;
        @(negedge clk);
        check(!acc_gnt && ras_n, "R5", "grant released", {acc_gnt, ras_n}, 1);

        // Pending refreshes served before the next grant
        align_to_refresh();
        acc_req = 1'b1;
        repeat (3 * PER + 100) @(negedge clk);
        acc_req = 1'b0;
        c0 = cbr_cnt;
        @(negedge clk);
        acc_req = 1'b1;
        wait_gnt(200, w);
        check(acc_gnt && cbr_cnt - c0 == 3, "R6", "pending refreshes before grant", cbr_cnt - c0, 3);
        acc_req = 1'b0;
        @(negedge clk);

        // Overflow of pending refreshes
        align_to_refresh();
        acc_req = 1'b1;
        repeat (7 * PER + 100) @(negedge clk);
        check(!ovf_err, "R7", "no error at 7 pending", ovf_err, 0);
        repeat (PER) @(negedge clk);
        check(!ovf_err, "R6", "8 pending accepted", ovf_err, 0);
        repeat (PER) @(negedge clk);
        check(ovf_err, "R7", "error on 9th request", ovf_err, 1);
        acc_req = 1'b0;
        c0 = cbr_cnt;
        @(negedge clk);
        acc_req = 1'b1;
        wait_gnt(300, w);
        check(acc_gnt && cbr_cnt - c0 == 8, "R6", "8 refreshes flushed", cbr_cnt - c0, 8);
        acc_req = 1'b0;
        repeat (50) @(negedge clk);
        check(ovf_err, "R7", "error sticky", ovf_err, 1);
        do_reset(1'b0);
        @(negedge clk);
        check(!ovf_err, "R1", "error cleared by reset", ovf_err, 0);

        // RAS-only refresh
        do_reset(1'b1);
        repeat (3 * PER + 20) @(negedge clk);
        check(ror_cnt == 3 && cbr_cnt == 0, "R4", "RAS-only cycles", ror_cnt, 3);
        check(row_addr == 10'd3, "R4", "row counter stepped", row_addr, 3);

        // Self refresh, CBR mode
        do_reset(1'b0);
        sleep_req = 1'b1;
        w = 0;
        while (!sleep_ack && w < 60) begin @(negedge clk); w++; end
        check(sleep_ack, "R8", "ack seen", sleep_ack, 1);
        c0 = cbr_cnt + ror_cnt;
        w = 0;
        for (int i = 0; i < 3 * PER; i++) begin
            @(negedge clk);
            if (ras_n || casl_n) w++;
        end
        check(w == 0 && cbr_cnt + ror_cnt == c0, "R8", "RAS/CAS held low asleep", w, 0);
        sleep_req = 1'b0;
        acc_req = 1'b1;
        @(negedge clk);
        check(!sleep_ack && ras_n, "R9", "exit raises RAS", {sleep_ack, ras_n}, 1);
        wait_gnt(TRPS + TCSR + TRAS + TRP + 4, w);
        check(acc_gnt, "R10", "grant soon after wake", w, TRPS + 1);
        check(cbr_cnt + ror_cnt - c0 <= 1, "R10", "no burst after wake", cbr_cnt + ror_cnt - c0, 0);
        acc_req = 1'b0;
        @(negedge clk);

        // Self refresh, RAS-only mode: catch-up burst
        do_reset(1'b1);
        sleep_req = 1'b1;
        w = 0;
        while (!sleep_ack && w < 60) begin @(negedge clk); w++; end
        check(sleep_ack, "R8", "ack seen, RAS-only mode", sleep_ack, 1);
        repeat (50) @(negedge clk);
        c0 = ror_cnt;
        sleep_req = 1'b0;
        acc_req = 1'b1;
        wait_gnt(12000, w);
        check(acc_gnt && ror_cnt - c0 >= 1024, "R11", "catch-up before grant", ror_cnt - c0, 1024);
        check(ror_cnt - c0 <= 1024 + 50, "R11", "catch-up length", ror_cnt - c0, 1024);
        acc_req = 1'b0;
        @(negedge clk);

        // Random access traffic, CBR mode
        do_reset(1'b0);
        while (cyc < 4000) begin
            idle = int'($urandom_range(30, 0));
            repeat (idle) @(negedge clk);
            acc_req = 1'b1;
            wait_gnt(100, w);
            check(acc_gnt, "R5", "random grant", w, 0);
            hold = int'($urandom_range(40, 1));
            repeat (hold) @(negedge clk);
            acc_req = 1'b0;
            @(negedge clk);
            check(!acc_gnt, "R5", "random release", acc_gnt, 0);
        end
        repeat (30) @(negedge clk);
        check(cbr_cnt <= exp_refresh(cyc) && cbr_cnt >= exp_refresh(cyc) - 1, "R2",
              "refresh count under traffic", cbr_cnt, exp_refresh(cyc));
        check(!ovf_err, "R6", "no overflow under traffic", ovf_err, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule